// File: doc/BRIEF.md
# Ambient-light window alarm with persistence filter

This block watches the stream of conversion results from a light-sensing converter. It flags the ones whose upper byte falls outside a window set by two 8-bit limits. The interrupt line is pulled low only after a selectable number of such results have arrived back to back. A short burst of out-of-range light, such as a camera flash, therefore passes without an alarm, while a lasting change in ambient level is reported.

The interrupt pin is modelled as an open-drain pull-down. It has a pull-down enable and the line level that results from an external pull-up. Once raised, the alarm stays latched until the host pulses the clear input. The limits and the persistence select are plain inputs, held steady by the register file that drives them.

Top module: `lux_window_alarm`

## Requirements
- R1: After reset `int_oe` is 0, `int_n` is 1, and the run count is zero, so a fresh alarm needs the full persistence run.
- R2: A result counts as above the window when its upper byte `res_data[15:8]`, as unsigned, is strictly greater than `thr_hi`; equality is inside the window.
- R3: A result counts as below the window when its upper byte is strictly less than `thr_lo`; equality is inside the window.
- R4: `pers_sel` sets the run length: 0 needs 1 result, 1 needs 4, 2 needs 8, 3 needs 16. `int_oe` rises on the clock edge that samples the qualifying out-of-window result with `res_valid` high.
- R5: A result with `res_valid` high that lies inside the window resets the run count to zero.
- R6: Cycles with `res_valid` low change neither the run count nor the alarm, whatever `res_data` holds.
- R7: Once set, the alarm stays set until a cycle with `int_clr` high. That cycle drops it on the next edge and also resets the run count to zero.
- R8: If a qualifying result and `int_clr` arrive in the same cycle, the alarm is set (or stays set).
- R9: The pin only pulls low: `int_n` is 0 exactly when `int_oe` is 1, and is 1 (released, pulled up) otherwise.
- R10: The low byte `res_data[7:0]` has no effect on the window decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | 16 | Conversion result |
| thr_hi | input | 8 | Upper window limit |
| thr_lo | input | 8 | Lower window limit |
| pers_sel | input | 2 | Persistence select (1, 4, 8 or 16 results) |
| int_clr | input | 1 | Alarm clear, active high for one cycle |
| int_oe | output | 1 | Pull-down enable of the interrupt pin |
| int_n | output | 1 | Resolved interrupt line level, active low |

## Verification
The assertions assume that `thr_hi`, `thr_lo` and `pers_sel` are quasi-static: they change only between runs, never while a count is building. The bench changes them only after a clear, when the count is zero. The assertions also assume `res_valid` is a single-cycle strobe. Every stimulus task therefore raises it for exactly one cycle and drops it before the next result, and `int_clr` is pulsed the same way.

// File: rtl/lux_alarm_pkg.sv
`timescale 1ns/1ps
package lux_alarm_pkg;
  localparam int SEL_W    = 2;
  localparam int PERS_MAX = 16;
  localparam int CNT_W    = $clog2(PERS_MAX + 1);

  typedef logic [CNT_W-1:0] run_t;

  // Run length required for a persistence select: 1, 4, 8, 16.
  function automatic run_t pers_need(input logic [SEL_W-1:0] sel);
    if (sel == '0) return run_t'(1);
    return run_t'(2 << sel);
  endfunction

  // Saturating increment of the run count.
  function automatic run_t run_step(input run_t c);
    if (c >= run_t'(PERS_MAX)) return c;
    return c + run_t'(1);
  endfunction
endpackage

// File: rtl/window_compare.sv
`timescale 1ns/1ps
module window_compare #(
  parameter int THR_W = 8
) (
  input  logic [THR_W-1:0] level,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  output logic             above,
  output logic             below,
  output logic             outside
);
  always_comb begin
    above   = level > thr_hi;
    below   = level < thr_lo;
    outside = above | below;
  end
endmodule

// File: rtl/persist_counter.sv
`timescale 1ns/1ps
module persist_counter
  import lux_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             outside,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output run_t             run_cnt,
  output logic             trip
);
  run_t cnt_q;
  run_t cnt_inc;

  always_comb begin
    cnt_inc = run_step(cnt_q);
    trip    = step & outside & (cnt_inc >= pers_need(sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= outside ? cnt_inc : '0;
  end

  assign run_cnt = cnt_q;
endmodule

// File: rtl/alarm_latch.sv
`timescale 1ns/1ps
module alarm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic active
);
  always_ff @(posedge clk) begin
    if (!rst_n)   active <= 1'b0;
    else if (set) active <= 1'b1;
    else if (clr) active <= 1'b0;
  end
endmodule

// File: rtl/lux_window_alarm.sv
`timescale 1ns/1ps
module lux_window_alarm
  import lux_alarm_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [SEL_W-1:0] pers_sel,
  input  logic             int_clr,
  output logic             int_oe,
  output logic             int_n
);
  localparam int LOW_W = RES_W - THR_W;

  logic [THR_W-1:0] level_w;
  logic             above_w, below_w, outside_w;
  logic             trip_w;
  run_t             run_cnt_w;
  logic             alarm_w;
  logic             unused_low_bits;

  assign level_w         = res_data[RES_W-1 -: THR_W];
  assign unused_low_bits = ^res_data[LOW_W-1:0];

  window_compare #(.THR_W(THR_W)) u_cmp (
    .level   (level_w),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .above   (above_w),
    .below   (below_w),
    .outside (outside_w)
  );

  persist_counter u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (res_valid),
    .outside (outside_w),
    .clr     (int_clr),
    .sel     (pers_sel),
    .run_cnt (run_cnt_w),
    .trip    (trip_w)
  );

  alarm_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (trip_w),
    .clr    (int_clr),
    .active (alarm_w)
  );

  // Open-drain pin: pull-down enabled while alarmed, released (pulled up) otherwise.
  assign int_oe = alarm_w;
  assign int_n  = ~alarm_w;
endmodule

// File: rtl/lux_window_alarm_chk.sv
`timescale 1ns/1ps
module lux_window_alarm_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             int_clr,
  input logic             int_oe,
  input logic             int_n,
  input logic             outside,
  input logic             trip,
  input logic [CNT_W-1:0] run_cnt
);
  // R4
  trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> int_oe);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_oe) |-> $past(trip));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_oe && !int_clr |=> int_oe);

  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr && !trip |=> !int_oe && run_cnt == '0);

  // R5
  inwin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !outside |=> run_cnt == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid && !int_clr |=> $stable(run_cnt) && $stable(int_oe));

  // R8
  collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip && int_clr |=> int_oe);

  // R9
  pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_oe) |-> $fell(int_n));
endmodule

bind lux_window_alarm lux_window_alarm_chk #(.CNT_W(lux_alarm_pkg::CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .int_clr   (int_clr),
  .int_oe    (int_oe),
  .int_n     (int_n),
  .outside   (outside_w),
  .trip      (trip_w),
  .run_cnt   (run_cnt_w)
);

// File: tb/lux_window_alarm_test.sv
`timescale 1ns/1ps
module lux_window_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [7:0]  thr_hi = 8'h80;
  logic [7:0]  thr_lo = 8'h20;
  logic [1:0]  pers_sel = 2'd0;
  logic        int_clr = 1'b0;
  logic        int_oe;
  logic        int_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lux_window_alarm uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .pers_sel(pers_sel), .int_clr(int_clr),
    .int_oe(int_oe), .int_n(int_n)
  );

  task automatic expect_pin(input logic exp_oe, input string tag);
    checks++;
    if (int_oe !== exp_oe || int_n !== ~exp_oe) begin
      errors++;
      $display("FAIL %s: int_oe=%b int_n=%b, expected int_oe=%b int_n=%b",
               tag, int_oe, int_n, exp_oe, ~exp_oe);
    end
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk) res_valid = 1'b1; res_data = v;
    @(negedge clk) res_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input logic [15:0] v);
    for (int i = 0; i < n; i++) send(v);
  endtask

  task automatic clear_alarm(input string tag);
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;
    expect_pin(1'b0, tag);
  endtask

  task automatic t_reset;
    expect_pin(1'b0, "R1 reset state");
    expect_pin(1'b0, "R9 released after reset");
  endtask

  task automatic t_single;
    pers_sel = 2'd0;
    send(16'h8100);
    expect_pin(1'b1, "R2 above upper, sel0 immediate (R4)");
    clear_alarm("R7 clear drops alarm");
  endtask

  task automatic t_edges;
    pers_sel = 2'd0;
    send(16'h80FF);
    expect_pin(1'b0, "R2 equal to upper is inside");
    send(16'h8000);
    expect_pin(1'b0, "R10 low byte ignored at upper edge");
    send(16'h2000);
    expect_pin(1'b0, "R3 equal to lower is inside");
    send(16'h1FFF);
    expect_pin(1'b1, "R3 below lower");
    clear_alarm("R7 clear after below");
    send(16'h7FFF);
    expect_pin(1'b0, "R10 low byte FF keeps 7F inside");
  endtask

  task automatic t_persist(input logic [1:0] sel, input int need);
    pers_sel = sel;
    send_n(need - 1, 16'hF000);
    expect_pin(1'b0, "R4 one short of run length");
    send(16'h0500);
    expect_pin(1'b1, "R4 run length reached");
    clear_alarm("R7 clear after persistence run");
  endtask

  task automatic t_inwin_reset;
    pers_sel = 2'd1;
    send_n(3, 16'hF000);
    send(16'h5000);
    send_n(3, 16'hF000);
    expect_pin(1'b0, "R5 in-window result restarted run");
    send(16'hF000);
    expect_pin(1'b1, "R5 fresh run of four completes");
    clear_alarm("R7 clear after R5 run");
  endtask

  task automatic t_idle;
    pers_sel = 2'd1;
    send_n(3, 16'hF000);
    @(negedge clk) res_data = 16'h5000;
    repeat (10) @(negedge clk);
    expect_pin(1'b0, "R6 idle cycles no alarm");
    send(16'hF000);
    expect_pin(1'b1, "R6 idle cycles kept count of three");
    clear_alarm("R7 clear after idle test");
  endtask

  task automatic t_latch;
    pers_sel = 2'd1;
    send_n(4, 16'hF000);
    expect_pin(1'b1, "R7 alarm set");
    send(16'h5000);
    repeat (5) @(negedge clk);
    expect_pin(1'b1, "R7 alarm held through in-window and idle");
    clear_alarm("R7 clear");
    send_n(3, 16'hF000);
    expect_pin(1'b0, "R7 clear reset run count");
    send(16'hF000);
    expect_pin(1'b1, "R7 re-alarm after fresh run");
    clear_alarm("R7 final clear");
  endtask

  task automatic t_collide;
    pers_sel = 2'd0;
    @(negedge clk) res_valid = 1'b1; res_data = 16'hFF00; int_clr = 1'b1;
    @(negedge clk) res_valid = 1'b0; int_clr = 1'b0;
    expect_pin(1'b1, "R8 set wins over clear");
    clear_alarm("R8 later clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_edges();
    t_persist(2'd1, 4);
    t_persist(2'd2, 8);
    t_persist(2'd3, 16);
    t_inwin_reset();
    t_idle();
    t_latch();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule